// File: doc/BRIEF.md
# Boosted Weighted Vote Accumulator

This block turns a vector of weak-classifier decision bits into one strong-classifier decision. Each bit stands for a vote of +1 or -1, and each vote carries a signed constant weight fixed when the design is built. The block outputs the sign of the weighted vote total. It uses no multiplier and no per-vote multiplexer. The decision bits are taken four at a time, and each group of four addresses a 16-entry constant table. Each table entry already holds the signed sum of the four weights for that bit pattern. A pipelined adder tree then combines the table outputs, and a final register captures the sign.

A new decision vector can enter on every clock cycle. Each vector is qualified by a valid strobe. The result appears a fixed number of cycles later, together with its own valid strobe. The weights come in as one packed parameter vector, so a new training run only needs a new parameter value and a rebuild.

Top module: `boost_vote_top`

## Requirements
- R1: For every accepted vector, `outClass` is 1 when the weighted total is zero or above, and 0 when it is below zero. In the total, a decision bit of 1 adds weight t and a decision bit of 0 subtracts it. Decision t sits at bit t of `inDecisions`, and weight t sits at bits [t*ALPHA_W +: ALPHA_W] of `ALPHAS`.
- R2: A weighted total of exactly zero gives `outClass` = 1.
- R3: `outValid` rises exactly ceil(log2(ceil(NUM_WEAK/4))) + 2 cycles after the cycle in which `inValid` was sampled high. With the default ten weights this is 4 cycles.
- R4: Vectors offered on consecutive cycles each produce one result, in the order they arrived, with no stall.
- R5: While `inValid` is low, `inDecisions` has no effect. No result appears for that cycle, and `outClass` keeps its last value whenever `outValid` is low.
- R6: When NUM_WEAK is not a multiple of four, the unused table inputs of the last group count as zero weight. Decisions 8 and 9 of the default ten-weight setup share a group with two such empty slots.
- R7: While `rstN` is low, `outValid` and `outClass` are both 0.
- R8: The extreme totals give the correct sign without overflow. With the default weights, all decision bits at 1 gives a total of +34 (class 1), and all bits at 0 gives -34 (class 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies `inDecisions` in this cycle |
| inDecisions | input | NUM_WEAK | Weak-classifier decisions, 1 = +1 vote, 0 = -1 vote |
| outValid | output | 1 | `outClass` carries a new result |
| outClass | output | 1 | Strong-classifier decision, 1 = +1 class, 0 = -1 class |

## Verification
The bench sweeps all 1024 decision vectors of the ten-weight default back to back. This would expose a table entry that uses the wrong sign for one bit position, or a padding slot in the last group that picks up a nonzero weight. Either fault flips the class for some patterns. A second sweep leaves gaps while the inputs keep changing. A design that leaked idle data would emit extra results there, and one that failed to hold its output would let the class move between results. The bench also aims at a total of exactly zero, where a design with the wrong tie rule reports class 0, and at the all-ones and all-zeros totals, where an adder tree with too few bits wraps around and reports the opposite sign.

// File: rtl/boost_vote_pkg.sv
package boost_vote_pkg;

  // Deepest adder tree the strobe struct can steer (256 groups).
  localparam int MAX_LEVELS = 8;

  // Per-stage load enables from control to datapath.
  typedef struct packed {
    logic                  lutEn;   // capture table outputs
    logic [MAX_LEVELS-1:0] treeEn;  // bit l loads tree level l+1
    logic                  signEn;  // capture the sign of the total
  } stage_strobe_t;

endpackage

// File: rtl/boost_vote_table.sv
// Constant 16-entry table: entry e is the signed sum of the four group
// weights, each added when bit k of e is 1 and subtracted when it is 0.
module boost_vote_table #(
  parameter int ALPHA_W = 6,
  parameter int ENTRY_W = ALPHA_W + 2,
  parameter logic [4*ALPHA_W-1:0] GROUP_ALPHAS = '0
) (
  input  logic [3:0]                addr,
  output logic signed [ENTRY_W-1:0] entry
);

  function automatic int entryValue(int pattern);
    int s;
    logic signed [ALPHA_W-1:0] a;
    s = 0;
    for (int k = 0; k < 4; k++) begin
      a = GROUP_ALPHAS[k*ALPHA_W +: ALPHA_W];
      if (pattern[k]) s += int'(a);
      else            s -= int'(a);
    end
    return s;
  endfunction

  logic signed [ENTRY_W-1:0] rom [16];

  for (genvar e = 0; e < 16; e++) begin : g_rom
    assign rom[e] = ENTRY_W'(entryValue(e));
  end

  assign entry = rom[addr];

endmodule

// File: rtl/boost_vote_ctrl.sv
// Valid pipeline; issues one load strobe per datapath stage.
module boost_vote_ctrl
  import boost_vote_pkg::*;
#(
  parameter int LEVELS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stage_strobe_t strobe,
  output logic          outValid
);

  localparam int LATENCY = LEVELS + 2;

  logic [LATENCY-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[LATENCY-2:0], inValid};
  end

  always_comb begin
    strobe       = '0;
    strobe.lutEn = inValid;
    for (int l = 0; l < LEVELS; l++) strobe.treeEn[l] = vPipe[l];
    strobe.signEn = vPipe[LEVELS];
  end

  assign outValid = vPipe[LATENCY-1];

endmodule

// File: rtl/boost_vote_dp.sv
// Table stage, registered adder tree (one register per level), sign stage.
module boost_vote_dp
  import boost_vote_pkg::*;
#(
  parameter int NUM_WEAK = 10,
  parameter int ALPHA_W  = 6,
  parameter logic [NUM_WEAK*ALPHA_W-1:0] ALPHAS = '0,
  parameter int LEVELS   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  stage_strobe_t       strobe,
  input  logic [NUM_WEAK-1:0] decisions,
  output logic                classOut
);

  localparam int ENTRY_W = ALPHA_W + 2;
  localparam int NPAD    = 1 << LEVELS;
  localparam int PADBITS = NPAD*4 - NUM_WEAK;

  function automatic logic [ALPHA_W-1:0] alphaOf(int t);
    if (t >= NUM_WEAK) return '0;
    return ALPHAS[t*ALPHA_W +: ALPHA_W];
  endfunction

  logic [NPAD*4-1:0] decPad;
  if (PADBITS > 0) begin : g_pad
    assign decPad = {{PADBITS{1'b0}}, decisions};
  end else begin : g_nopad
    assign decPad = decisions;
  end

  logic signed [ENTRY_W-1:0] tableOut [NPAD];

  for (genvar g = 0; g < NPAD; g++) begin : g_grp
    boost_vote_table #(
      .ALPHA_W     (ALPHA_W),
      .ENTRY_W     (ENTRY_W),
      .GROUP_ALPHAS({alphaOf(4*g+3), alphaOf(4*g+2), alphaOf(4*g+1), alphaOf(4*g)})
    ) u_tbl (
      .addr (decPad[4*g +: 4]),
      .entry(tableOut[g])
    );
  end

  // Level l holds NPAD>>l partial sums, each ENTRY_W+l bits wide.
  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int NODES = NPAD >> l;
    localparam int W     = ENTRY_W + l;
    logic signed [W-1:0] sumQ [NODES];
    if (l == 0) begin : g_leaf
      always_ff @(posedge clk) begin
        if (strobe.lutEn)
          for (int i = 0; i < NODES; i++) sumQ[i] <= tableOut[i];
      end
    end else begin : g_node
      always_ff @(posedge clk) begin
        if (strobe.treeEn[l-1])
          for (int i = 0; i < NODES; i++)
            sumQ[i] <= W'(lvl[l-1].sumQ[2*i]) + W'(lvl[l-1].sumQ[2*i+1]);
      end
    end
  end

  logic signed [ENTRY_W+LEVELS-1:0] total;
  assign total = lvl[LEVELS].sumQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              classOut <= 1'b0;
    else if (strobe.signEn) classOut <= ~total[ENTRY_W+LEVELS-1];
  end

  wire unusedTreeEn = ^strobe.treeEn;

endmodule

// File: rtl/boost_vote_top.sv
module boost_vote_top
  import boost_vote_pkg::*;
#(
  parameter int NUM_WEAK = 10,
  parameter int ALPHA_W  = 6,
  parameter logic [NUM_WEAK*ALPHA_W-1:0] ALPHAS = {
    6'(25), 6'(-31), 6'(1), 6'(15), 6'(-9),
    6'(3),  6'(12),  6'(7), 6'(-20), 6'(31)}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [NUM_WEAK-1:0] inDecisions,
  output logic                outValid,
  output logic                outClass
);

  localparam int GROUPS  = (NUM_WEAK + 3) / 4;
  localparam int LEVELS  = $clog2(GROUPS);
  localparam int LATENCY = LEVELS + 2;

  stage_strobe_t strobe;

  boost_vote_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  boost_vote_dp #(
    .NUM_WEAK(NUM_WEAK),
    .ALPHA_W (ALPHA_W),
    .ALPHAS  (ALPHAS),
    .LEVELS  (LEVELS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .decisions(inDecisions),
    .classOut (outClass)
  );

endmodule

// File: rtl/boost_vote_chk.sv
module boost_vote_chk #(
  parameter int NUM_WEAK = 10,
  parameter int ALPHA_W  = 6,
  parameter logic [NUM_WEAK*ALPHA_W-1:0] ALPHAS = '0,
  parameter int LATENCY  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [NUM_WEAK-1:0] inDecisions,
  input logic                outValid,
  input logic                outClass
);

  function automatic int voteTotal(logic [NUM_WEAK-1:0] d);
    int s;
    logic signed [ALPHA_W-1:0] a;
    s = 0;
    for (int t = 0; t < NUM_WEAK; t++) begin
      a = ALPHAS[t*ALPHA_W +: ALPHA_W];
      s += d[t] ? int'(a) : -int'(a);
    end
    return s;
  endfunction

  logic refClass;
  always_comb refClass = (voteTotal(inDecisions) >= 0);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##LATENCY outValid);

  // R5
  spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, LATENCY));

  // R1
  class_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outClass == $past(refClass, LATENCY)));

  // R5
  class_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outClass));

endmodule

bind boost_vote_top boost_vote_chk #(
  .NUM_WEAK(NUM_WEAK),
  .ALPHA_W (ALPHA_W),
  .ALPHAS  (ALPHAS),
  .LATENCY (LATENCY)
) u_chk (.*);

// File: tb/boost_vote_top_tb.sv
module boost_vote_top_tb;

  localparam int T   = 10;
  localparam int AW  = 6;
  // ten weights -> three groups -> two tree levels -> 2 + 2 cycles
  localparam int LAT = 4;

  int alpha [T] = '{31, -20, 7, 12, 3, -9, 15, 1, -31, 25};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [T-1:0] inDecisions = '0;
  logic         outValid;
  logic         outClass;

  boost_vote_top #(
    .NUM_WEAK(T),
    .ALPHA_W (AW),
    .ALPHAS  ({6'(25), 6'(-31), 6'(1), 6'(15), 6'(-9),
               6'(3), 6'(12), 6'(7), 6'(-20), 6'(31)})
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDecisions(inDecisions),
    .outValid(outValid), .outClass(outClass)
  );

  always #5 clk = ~clk;

  int    nTests = 0;
  int    nFail  = 0;
  bit    expV [LAT];
  bit    expC [LAT];
  string expTag [LAT];
  bit    lastClass = 1'b0;

  function automatic int refSum(logic [T-1:0] d);
    int s = 0;
    for (int t = 0; t < T; t++) s += d[t] ? alpha[t] : -alpha[t];
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare outputs against the vector offered LAT negedges ago, then offer a new one.
  task automatic step(bit v, logic [T-1:0] d, string tag);
    @(negedge clk);
    check(outValid == expV[LAT-1], "R3", "outValid", int'(outValid), int'(expV[LAT-1]));
    if (expV[LAT-1]) begin
      check(outClass == expC[LAT-1], expTag[LAT-1], "outClass", int'(outClass), int'(expC[LAT-1]));
      lastClass = expC[LAT-1];
    end else begin
      check(outClass == lastClass, "R5", "outClass hold", int'(outClass), int'(lastClass));
    end
    for (int i = LAT-1; i > 0; i--) begin
      expV[i] = expV[i-1]; expC[i] = expC[i-1]; expTag[i] = expTag[i-1];
    end
    expV[0] = v; expC[0] = (refSum(d) >= 0); expTag[0] = tag;
    inValid = v;
    inDecisions = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [T-1:0] zeroPat;
    bit found;
    for (int i = 0; i < LAT; i++) begin expV[i] = 0; expC[i] = 0; expTag[i] = "R1"; end

    // R7: quiet outputs while in reset
    inDecisions = '1;
    inValid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(outValid == 1'b0, "R7", "outValid in reset", int'(outValid), 0);
      check(outClass == 1'b0, "R7", "outClass in reset", int'(outClass), 0);
    end
    inValid = 1'b0;
    inDecisions = '0;
    @(negedge clk);
    rstN = 1'b1;

    // R1/R4: every pattern, back to back
    for (int p = 0; p < (1 << T); p++) step(1'b1, T'(p), "R1/R4");
    repeat (LAT + 1) step(1'b0, '0, "R5");

    // R5: gaps with changing ignored data
    for (int p = 0; p < 300; p++)
      step((p % 3) != 0, T'((p * 37 + 11) % (1 << T)), "R5");
    repeat (LAT + 1) step(1'b0, '1, "R5");

    // R2: a pattern whose total is exactly zero
    found = 0;
    zeroPat = '0;
    for (int p = 0; p < (1 << T); p++)
      if (!found && refSum(T'(p)) == 0) begin found = 1; zeroPat = T'(p); end
    check(found, "R2", "zero-total pattern exists", int'(found), 1);
    step(1'b1, zeroPat, "R2");
    step(1'b0, '0, "R5");

    // R8: extreme totals (+34 and -34)
    check(refSum('1) == 34, "R8", "all-ones total", refSum('1), 34);
    step(1'b1, '1, "R8");
    step(1'b1, '0, "R8");

    // R6: decisions in the padded last group
    step(1'b1, T'(1 << 8), "R6");
    step(1'b1, T'(1 << 9), "R6");
    step(1'b1, T'(3 << 8), "R6");
    step(1'b1, ~T'(3 << 8), "R6");
    repeat (LAT + 2) step(1'b0, '0, "R5");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule